// File: doc/BRIEF.md
# Striped Multiport FIFO

This queue moves groups of data words between two pipeline stages that each have several lanes. Every word offered on the push lanes in the same cycle becomes one stripe. Stripes come out in the order they went in. Within a stripe the consumer may take the words in any order and spread over any number of cycles.

In any cycle the pop lanes carry only the oldest stripe that still holds words. The remaining words of that stripe are packed toward lane 0, in ascending push-lane order. A stripe that is only partly drained stays at the head, and the next stripe waits behind it even when pop lanes are idle. This rule keeps the order between cycles without the cost of packing words across stripe boundaries.

Storage is counted in stripe slots. Each slot holds one data word per lane and a per-lane occupancy mask. A single full flag covers the whole push side.

Top module: `sfifo_striped`

## Requirements
- R1: `full` is high exactly when all DEPTH stripe slots are occupied. Every bit of `push_ready` equals the inverse of `full`.
- R2: A push cycle in which no `push_valid` bit is set occupies no slot. The queue stays empty and `full` does not change.
- R3: A stripe pushed into an empty queue does not appear on the pop lanes in the cycle it is pushed. It appears on the next cycle.
- R4: `pop_valid[k]` is high exactly when the head stripe still holds more than k words. The valid lanes therefore always form a run starting at lane 0.
- R5: Pop lane k carries the k-th remaining word of the head stripe, counting by ascending push-lane index. Lane k occupies bits [k*WIDTH +: WIDTH].
- R6: Stripes leave in push order. The pop lanes never carry a word of a younger stripe while the head stripe holds any word.
- R7: The number of words popped in a cycle is the length of the run of set bits of `pop_ready & pop_valid` starting at lane 0. Words beyond that run stay in the head stripe for later cycles.
- R8: When every lane holding a word of the head stripe is ready, the whole stripe leaves in that one cycle.
- R9: The slot of the head stripe is freed in the cycle its last word is popped. When the queue was full, `full` is low on the next cycle.
- R10: Synchronous reset, active high, empties all slots: `pop_valid` is all zero and `full` is low.
- R11: A push offered while `full` is high is discarded. None of its words ever appears on the pop lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | LANES | Per-lane word present on the push side |
| push_data | input | LANES*WIDTH | Push words, lane k at bits [k*WIDTH +: WIDTH] |
| push_ready | output | LANES | Per-lane push acceptance (all equal to not full) |
| full | output | 1 | All stripe slots occupied |
| pop_valid | output | LANES | Per-lane word available from the head stripe |
| pop_ready | input | LANES | Per-lane consumer acceptance |
| pop_data | output | LANES*WIDTH | Packed head-stripe words, lane k at bits [k*WIDTH +: WIDTH] |

## Verification
The assertions check the following on every cycle:
- the pop valids always form a run starting at lane 0;
- a partial pop shrinks the head by exactly the accepted run length;
- a push into an empty queue shows up one cycle later with its own word count;
- `full` holds while nothing is popped, and drops after the last word of the head leaves.

The data-dependent behaviours can only be shown by the directed scenarios:
- which word lands on which lane;
- that a younger stripe stays hidden behind a partly drained head;
- that a non-prefix ready pattern takes nothing;
- that a push refused while full never surfaces later.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int MAX_LANES = 32;

    // Decision taken on the head stripe in one cycle
    typedef struct packed {
        logic consume;  // at least one word leaves
        logic retire;   // head stripe emptied, slot freed
    } head_op_t;

    // Length of the run of ones starting at bit 0
    function automatic int lead_ones(input logic [MAX_LANES-1:0] v);
        int  n;
        bit  stop;
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (!stop) begin
                if (v[i]) n++;
                else      stop = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic int ones(input logic [MAX_LANES-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < MAX_LANES; i++) if (v[i]) n++;
        return n;
    endfunction

endpackage

// File: rtl/sfifo_stripe_store.sv
module sfifo_stripe_store #(
    parameter int LANES = 4,
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_ptr,
    input  logic [LANES-1:0]       wr_mask,
    input  logic [LANES*WIDTH-1:0] wr_data,
    input  logic                   upd_en,
    input  logic [PW-1:0]          upd_ptr,
    input  logic [LANES-1:0]       upd_mask,
    input  logic [PW-1:0]          rd_ptr,
    output logic [LANES-1:0]       rd_mask,
    output logic [LANES*WIDTH-1:0] rd_data
);

    logic [LANES-1:0]       mask_q [DEPTH];
    logic [LANES*WIDTH-1:0] data_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[s] <= '0;
            end else if (wr_en && wr_ptr == PW'(s)) begin
                mask_q[s] <= wr_mask;
            end else if (upd_en && upd_ptr == PW'(s)) begin
                mask_q[s] <= upd_mask;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PW'(s)) data_q[s] <= wr_data;
        end
    end

    assign rd_mask = mask_q[rd_ptr];
    assign rd_data = data_q[rd_ptr];

endmodule

// File: rtl/sfifo_lane_pack.sv
module sfifo_lane_pack #(
    parameter int LANES = 4,
    parameter int WIDTH = 8,
    localparam int TW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]       mask,
    input  logic [LANES*WIDTH-1:0] data,
    input  logic [TW-1:0]          take,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*WIDTH-1:0] out_data,
    output logic [LANES-1:0]       remain
);

    // Pack the remaining words toward lane 0 and clear the first 'take' of them
    always_comb begin
        int rank;
        rank      = 0;
        out_data  = '0;
        out_valid = '0;
        remain    = mask;
        for (int j = 0; j < LANES; j++) begin
            if (mask[j]) begin
                for (int k = 0; k < LANES; k++) begin
                    if (rank == k) out_data[k*WIDTH +: WIDTH] = data[j*WIDTH +: WIDTH];
                end
                if (rank < int'(take)) remain[j] = 1'b0;
                rank++;
            end
        end
        for (int k = 0; k < LANES; k++) out_valid[k] = (rank > k);
    end

endmodule

// File: rtl/sfifo_striped.sv
module sfifo_striped #(
    parameter int LANES = 4,
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       push_valid,
    input  logic [LANES*WIDTH-1:0] push_data,
    output logic [LANES-1:0]       push_ready,
    output logic                   full,
    output logic [LANES-1:0]       pop_valid,
    input  logic [LANES-1:0]       pop_ready,
    output logic [LANES*WIDTH-1:0] pop_data
);
    import sfifo_pkg::*;

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TW = $clog2(LANES + 1);
    localparam int ML = MAX_LANES;

    logic [PW-1:0]    head_q, tail_q;
    logic [CW-1:0]    cnt_q;
    logic [LANES-1:0] head_mask, remain;
    logic [LANES*WIDTH-1:0] head_data;
    logic [TW-1:0]    take;
    logic             push_go;
    head_op_t         op;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (cnt_q == CW'(DEPTH));
    assign push_ready = {LANES{~full}};
    assign push_go    = (|push_valid) && !full;

    sfifo_stripe_store #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (push_go),
        .wr_ptr   (tail_q),
        .wr_mask  (push_valid),
        .wr_data  (push_data),
        .upd_en   (op.consume),
        .upd_ptr  (head_q),
        .upd_mask (remain),
        .rd_ptr   (head_q),
        .rd_mask  (head_mask),
        .rd_data  (head_data)
    );

    sfifo_lane_pack #(.LANES(LANES), .WIDTH(WIDTH)) u_pack (
        .mask      (head_mask),
        .data      (head_data),
        .take      (take),
        .out_valid (pop_valid),
        .out_data  (pop_data),
        .remain    (remain)
    );

    assign take       = TW'(lead_ones(ML'(pop_ready & pop_valid)));
    assign op.consume = (take != '0);
    assign op.retire  = op.consume && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_go)   tail_q <= step(tail_q);
            if (op.retire) head_q <= step(head_q);
            if (push_go && !op.retire)      cnt_q <= cnt_q + 1'b1;
            else if (!push_go && op.retire) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sfifo_striped_chk.sv
module sfifo_striped_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] push_valid,
    input logic             full,
    input logic [LANES-1:0] pop_valid,
    input logic [LANES-1:0] pop_ready
);
    import sfifo_pkg::*;

    localparam int ML = MAX_LANES;
    localparam logic [LANES-1:0] ONE = LANES'(1);

    int taken;
    assign taken = lead_ones(ML'(pop_ready & pop_valid));

    // R4
    valid_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (((pop_valid + ONE) & pop_valid) == '0));

    // R7
    partial_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (taken < $countones(pop_valid)) |=>
        ($countones(pop_valid) == $past($countones(pop_valid) - taken)));

    // R3
    empty_push_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_valid == '0 && !full && |push_valid) |=>
        ($countones(pop_valid) == $past($countones(push_valid))));

    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && taken == 0) |=> full);

    // R9
    retire_free_chk: assert property (@(posedge clk) disable iff (rst)
        (full && pop_valid != '0 && taken == $countones(pop_valid)) |=> !full);

    // R10
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (pop_valid == '0 && !full));

endmodule

bind sfifo_striped sfifo_striped_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .full       (full),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready)
);

// File: tb/sfifo_striped_tb.sv
module sfifo_striped_tb;

    localparam int LANES = 4;
    localparam int WIDTH = 8;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LANES-1:0]       push_valid = '0;
    logic [LANES*WIDTH-1:0] push_data  = '0;
    logic [LANES-1:0]       push_ready;
    logic                   full;
    logic [LANES-1:0]       pop_valid;
    logic [LANES-1:0]       pop_ready  = '0;
    logic [LANES*WIDTH-1:0] pop_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sfifo_striped #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .full(full), .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data)
    );

    typedef struct packed {
        logic [3:0]  pv;
        logic [31:0] pd;
        logic [3:0]  pr;
        logic [3:0]  ev;
        logic [31:0] ed;
        logic        ef;
    } row_t;

    localparam int NROWS = 20;
    // Each row: outputs checked before the edge, inputs applied at the edge
    localparam row_t ROWS [NROWS] = '{
        '{4'h0, 32'h0,        4'h0, 4'h0, 32'h0,        1'b0},  // R10 empty after reset
        '{4'h0, 32'hEEEEEEEE, 4'h0, 4'h0, 32'h0,        1'b0},  // R2 push, no valid lanes
        '{4'h0, 32'h0,        4'h0, 4'h0, 32'h0,        1'b0},  // R2 nothing stored
        '{4'hF, 32'hA3A2A1A0, 4'hF, 4'h0, 32'h0,        1'b0},  // R3 push A, not yet visible
        '{4'h5, 32'hB3B2B1B0, 4'hF, 4'hF, 32'hA3A2A1A0, 1'b0},  // R8 A leaves whole; push B lanes 0,2
        '{4'hA, 32'hC3C2C1C0, 4'h1, 4'h3, 32'h0000B2B0, 1'b0},  // R5 packed B; R7 pop one; push C
        '{4'h0, 32'h0,        4'h0, 4'h1, 32'h000000B2, 1'b0},  // R6 only B2 though C waits
        '{4'h0, 32'h0,        4'h2, 4'h1, 32'h000000B2, 1'b0},  // R7 non-prefix ready takes none
        '{4'h0, 32'h0,        4'hF, 4'h1, 32'h000000B2, 1'b0},  // R7 B2 leaves
        '{4'hF, 32'hD3D2D1D0, 4'h0, 4'h3, 32'h0000C3C1, 1'b0},  // R5 C packed; push D
        '{4'h1, 32'hE3E2E1E0, 4'h0, 4'h3, 32'h0000C3C1, 1'b0},  // push E
        '{4'h8, 32'hF3F2F1F0, 4'h0, 4'h3, 32'h0000C3C1, 1'b0},  // push F
        '{4'hF, 32'h99999999, 4'h0, 4'h3, 32'h0000C3C1, 1'b1},  // R1 full; R11 push dropped
        '{4'h0, 32'h0,        4'h3, 4'h3, 32'h0000C3C1, 1'b1},  // R9 C retires while full
        '{4'h6, 32'h13121110, 4'h7, 4'hF, 32'hD3D2D1D0, 1'b0},  // R9 full dropped; push H
        '{4'h0, 32'h0,        4'h1, 4'h1, 32'h000000D3, 1'b1},  // R7 D3 left over
        '{4'h0, 32'h0,        4'h1, 4'h1, 32'h000000E0, 1'b0},  // R6 E next
        '{4'h0, 32'h0,        4'h1, 4'h1, 32'h000000F3, 1'b0},  // R5 F3 on lane 0
        '{4'h0, 32'h0,        4'hF, 4'h3, 32'h00001211, 1'b0},  // R11 H, no trace of dropped push
        '{4'h0, 32'h0,        4'h0, 4'h0, 32'h0,        1'b0}   // empty again
    };

    task automatic check_outputs(input string tag, input logic [3:0] ev,
                                 input logic [31:0] ed, input logic ef);
        logic [31:0] dm;
        dm = '0;
        for (int k = 0; k < LANES; k++) if (ev[k]) dm[k*WIDTH +: WIDTH] = '1;
        checks++;
        if (pop_valid !== ev) begin
            errors++;
            $display("FAIL %s R4 pop_valid actual=%h expected=%h", tag, pop_valid, ev);
        end
        checks++;
        if ((pop_data & dm) !== (ed & dm)) begin
            errors++;
            $display("FAIL %s R5 pop_data actual=%h expected=%h", tag, pop_data & dm, ed & dm);
        end
        checks++;
        if (full !== ef || push_ready !== {LANES{~ef}}) begin
            errors++;
            $display("FAIL %s R1 full/push_ready actual=%b/%h expected=%b/%h",
                     tag, full, push_ready, ef, {LANES{~ef}});
        end
    endtask

    task automatic drive(input logic [3:0] pv, input logic [31:0] pd, input logic [3:0] pr);
        @(negedge clk);
        push_valid = pv;
        push_data  = pd;
        pop_ready  = pr;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            drive(ROWS[i].pv, ROWS[i].pd, ROWS[i].pr);
            check_outputs($sformatf("row%0d", i), ROWS[i].ev, ROWS[i].ed, ROWS[i].ef);
        end

        // R1 fill all slots, push side must refuse
        for (int s = 0; s < DEPTH; s++) drive(4'h1, 32'h50 + 32'(s), 4'h0);
        drive(4'h0, 32'h0, 4'h0);
        check_outputs("fill R1", 4'h1, 32'h00000050, 1'b1);

        // R10 reset while full clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_outputs("reset R10", 4'h0, 32'h0, 1'b0);

        // R3 push after reset appears a cycle later, packed (R5)
        drive(4'hC, 32'h6B6A0000, 4'h0);
        check_outputs("post-reset push R3", 4'h0, 32'h0, 1'b0);
        drive(4'h0, 32'h0, 4'h3);
        check_outputs("post-reset data R3", 4'h3, 32'h00006B6A, 1'b0);
        drive(4'h0, 32'h0, 4'h0);
        check_outputs("drained R8", 4'h0, 32'h0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule